// File: doc/BRIEF.md
# Serial Command and Readback Slave

This block lets a host controller run a power converter core over a four-wire serial bus in mode 3 (clock idle high, data changed on the falling edge and sampled on the rising edge). Bytes travel most significant bit first, and the slave returns one byte for every byte it receives. The first byte of every frame is a command. Two commands produce a one-cycle control pulse toward the core: one for shutdown and one for turn-on. Four commands read a core value back: the measured current, the input voltage, the duty setting and a status word. To clock read data out, the host sends zero filler bytes after the command.

The bus pins are brought into the core clock domain through two-flop synchronizers, and edges are detected there. The register values therefore come straight from the core clock domain and need no handshake. The value a read returns is captured once, at command decode. Values wider than a byte are zero-extended to a whole number of bytes and sent upper byte first. If select is released part-way through a byte, the byte is dropped and the frame closes.

Top module: `spi_cmd_slave`

## Requirements
- R1: While reset is asserted, and whenever select (active low) is high, miso_o is 0, and shutdown_o and turn_on_o are 0.
- R2: Mode 3, MSB first: MOSI is sampled on rising SCLK edges. miso_o changes only after a falling SCLK edge or a select change, and bit 7 of each returned byte is valid before the first rising edge of that byte.
- R3: A frame whose command byte is 0x02 produces exactly one single-cycle pulse on shutdown_o. It is never high in the same cycle as turn_on_o.
- R4: A frame whose command byte is 0x03 produces exactly one single-cycle pulse on turn_on_o.
- R5: Command 0x04 returns the 10-bit current value as two bytes: {6'b0, cur[9:8]} first, then cur[7:0].
- R6: Command 0x05 returns the 10-bit input voltage value as two bytes: {6'b0, vin[9:8]} first, then vin[7:0].
- R7: Command 0x06 returns the 9-bit duty value as two bytes: {7'b0, duty[8]} first, then duty[7:0].
- R8: Command 0x07 returns one status byte. Bit 7 is 0, bits 6:3 are the per-phase overcurrent flags (phase 3 in bit 6 down to phase 0 in bit 3), bit 2 is overvoltage, bit 1 is overtemperature and bit 0 is the auxiliary flag.
- R9: A read returns the value sampled when the command byte completes. Later changes to the input during the same frame do not alter the bytes sent.
- R10: miso_o returns 0x00 during the command byte and for every byte after the read data has been sent.
- R11: Command codes 0x00, 0x01 and 0x08 to 0xFF produce no pulse and return only 0x00 bytes.
- R12: If select rises before the eighth bit of a byte, that byte has no effect. The next frame starts with a new command byte.
- R13: Only the first byte of a frame is decoded. A later byte of value 0x02 or 0x03 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host, idle high |
| sel_ni | input | 1 | Frame select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| cur_val_i | input | CUR_W | Current measurement from the core |
| vin_val_i | input | VIN_W | Input voltage measurement from the core |
| duty_val_i | input | DUTY_W | Duty setting from the core |
| oc_phase_i | input | PHASES | Per-phase overcurrent flags |
| ov_flag_i | input | 1 | Overvoltage flag |
| ot_flag_i | input | 1 | Overtemperature flag |
| aux_flag_i | input | 1 | Auxiliary status flag |
| shutdown_o | output | 1 | One-cycle shutdown request |
| turn_on_o | output | 1 | One-cycle turn-on request |

## Verification
The hardest case to reach from the ports is a select release in the middle of a byte, because the bus has to stop at an arbitrary bit count. The bench has a partial-byte task that clocks only a few bits of a shutdown code and then raises select. It then confirms that no pulse appears and that the next frame decodes normally. Capture at decode is tested by changing the current input between the command byte and the filler bytes. The bench also sends control codes as filler bytes to show that only the first byte of a frame is decoded.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [7:0] {
    CMD_RSVD    = 8'h00,
    CMD_NOP     = 8'h01,
    CMD_SHUT    = 8'h02,
    CMD_ON      = 8'h03,
    CMD_RD_CUR  = 8'h04,
    CMD_RD_VIN  = 8'h05,
    CMD_RD_DUTY = 8'h06,
    CMD_RD_STAT = 8'h07
  } spi_cmd_e;

  function automatic int bytes_for(input int w);
    return (w + 7) / 8;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {(STAGES+1){RST_VAL[g]}};
      else         chain <= {chain[STAGES-1:0], d_i[g]};
    end
    assign q_o[g]    = chain[STAGES-1];
    assign rise_o[g] =  chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] &  chain[STAGES];
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_next_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              load_o,
  output logic              miso_o
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  assign byte_done_o = sel_i && sclk_rise_i && (bit_cnt == LAST);
  assign rx_byte_o   = {rx_sh[BYTE_W-2:0], mosi_i};
  assign load_o      = sel_i && sclk_fall_i && (bit_cnt == '0);
  assign miso_o      = tx_sh[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (!sel_i) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (sclk_rise_i) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_i};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CW'(1);
      end
      if (sclk_fall_i) begin
        // first falling edge of a byte presents its MSB
        if (bit_cnt == '0) tx_sh <= tx_next_i;
        else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CUR_W  = 10,
  parameter int VIN_W  = 10,
  parameter int DUTY_W = 9,
  parameter int STAT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              load_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [VIN_W-1:0]  vin_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [7:0]        tx_next_o,
  output logic              shutdown_o,
  output logic              turn_on_o
);

  localparam int CUR_B  = bytes_for(CUR_W);
  localparam int VIN_B  = bytes_for(VIN_W);
  localparam int DUTY_B = bytes_for(DUTY_W);
  localparam int STAT_B = bytes_for(STAT_W);
  localparam int MAX_B  = max2(max2(CUR_B, VIN_B), max2(DUTY_B, STAT_B));
  localparam int HOLD_W = 8 * MAX_B;
  localparam int RW     = $clog2(MAX_B + 1);

  logic              cmd_seen;
  logic [HOLD_W-1:0] hold;
  logic [RW-1:0]     rem;
  logic [HOLD_W-1:0] shifted;
  int unsigned       idx;

  always_comb begin
    idx       = (rem == '0) ? 0 : 8 * (int'(rem) - 1);
    shifted   = hold >> idx;
    tx_next_o = (rem == '0) ? 8'h00 : shifted[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_seen   <= 1'b0;
      hold       <= '0;
      rem        <= '0;
      shutdown_o <= 1'b0;
      turn_on_o  <= 1'b0;
    end else begin
      shutdown_o <= 1'b0;
      turn_on_o  <= 1'b0;
      if (!sel_i) begin
        cmd_seen <= 1'b0;
        rem      <= '0;
      end else if (byte_done_i && !cmd_seen) begin
        cmd_seen <= 1'b1;
        rem      <= '0;
        case (rx_byte_i)
          CMD_SHUT:    shutdown_o <= 1'b1;
          CMD_ON:      turn_on_o  <= 1'b1;
          CMD_RD_CUR:  begin hold <= HOLD_W'(cur_i);  rem <= RW'(CUR_B);  end
          CMD_RD_VIN:  begin hold <= HOLD_W'(vin_i);  rem <= RW'(VIN_B);  end
          CMD_RD_DUTY: begin hold <= HOLD_W'(duty_i); rem <= RW'(DUTY_B); end
          CMD_RD_STAT: begin hold <= HOLD_W'(stat_i); rem <= RW'(STAT_B); end
          default:     ;
        endcase
      end else if (load_i && cmd_seen && rem != '0) begin
        rem <= rem - RW'(1);
      end
    end
  end

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int CUR_W  = 10,
  parameter int VIN_W  = 10,
  parameter int DUTY_W = 9,
  parameter int PHASES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sel_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [CUR_W-1:0]  cur_val_i,
  input  logic [VIN_W-1:0]  vin_val_i,
  input  logic [DUTY_W-1:0] duty_val_i,
  input  logic [PHASES-1:0] oc_phase_i,
  input  logic              ov_flag_i,
  input  logic              ot_flag_i,
  input  logic              aux_flag_i,
  output logic              shutdown_o,
  output logic              turn_on_o
);

  localparam int STAT_W = PHASES + 3;

  // pin order: {select_n, sclk, mosi}
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       sel_act;
  logic       byte_done, load;
  logic [7:0] rx_byte, tx_next;
  logic [STAT_W-1:0] stat_vec;

  assign stat_vec = {oc_phase_i, ov_flag_i, ot_flag_i, aux_flag_i};
  assign sel_act  = ~pin_q[2];

  spi_pin_sync #(
    .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_ni, sclk_i, mosi_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  spi_byte_engine #(.BYTE_W(8)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_act),
    .sclk_rise_i (pin_rise[1]),
    .sclk_fall_i (pin_fall[1]),
    .mosi_i      (pin_q[0]),
    .tx_next_i   (tx_next),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .load_o      (load),
    .miso_o      (miso_o)
  );

  spi_cmd_ctrl #(
    .CUR_W(CUR_W), .VIN_W(VIN_W), .DUTY_W(DUTY_W), .STAT_W(STAT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_act),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .load_i      (load),
    .cur_i       (cur_val_i),
    .vin_i       (vin_val_i),
    .duty_i      (duty_val_i),
    .stat_i      (stat_vec),
    .tx_next_o   (tx_next),
    .shutdown_o  (shutdown_o),
    .turn_on_o   (turn_on_o)
  );

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_i,
  input logic sel_ni,
  input logic miso_o,
  input logic shutdown_o,
  input logic turn_on_o
);

  a_r3_shut_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  a_r4_on_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_on_o |=> !turn_on_o);

  a_r3_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_o && turn_on_o));

  // R1: deselected for several samples -> line quiet
  a_r1_miso_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni && $past(sel_ni) && $past(sel_ni, 2) && $past(sel_ni, 3)) |-> !miso_o);

  // R2: output only moves after a clock or select change reaches it
  a_r2_miso_moves_on_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i == $past(sclk_i) && $past(sclk_i) == $past(sclk_i, 2) &&
     $past(sclk_i, 2) == $past(sclk_i, 3) && $past(sclk_i, 3) == $past(sclk_i, 4) &&
     sel_ni == $past(sel_ni) && $past(sel_ni) == $past(sel_ni, 2) &&
     $past(sel_ni, 2) == $past(sel_ni, 3) && $past(sel_ni, 3) == $past(sel_ni, 4))
    |-> $stable(miso_o));

endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_i     (sclk_i),
  .sel_ni     (sel_ni),
  .miso_o     (miso_o),
  .shutdown_o (shutdown_o),
  .turn_on_o  (turn_on_o)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;

  localparam int HALF = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       sclk = 1'b1, sel_n = 1'b1, mosi = 1'b0;
  logic       miso, shut, on;
  logic [9:0] cur = '0, vin = '0;
  logic [8:0] duty = '0;
  logic [3:0] oc = '0;
  logic       ov = 1'b0, ot = 1'b0, aux = 1'b0;

  int tests = 0, fails = 0;
  int n_shut = 0, n_on = 0;
  bit done = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];

  spi_cmd_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sel_ni(sel_n), .mosi_i(mosi),
    .miso_o(miso), .cur_val_i(cur), .vin_val_i(vin), .duty_val_i(duty),
    .oc_phase_i(oc), .ov_flag_i(ov), .ot_flag_i(ot), .aux_flag_i(aux),
    .shutdown_o(shut), .turn_on_o(on)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock monitor of the control pulses
  always @(negedge clk) begin
    if (rst_ni) begin
      if (shut) n_shut++;
      if (on)   n_on++;
      if (shut && on) begin
        tests++; fails++;
        $display("FAIL R3: actual both pulses expected exclusive");
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1'b0; mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic sel_low;
    sel_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic sel_high;
    wait_clk(HALF); sel_n = 1'b1; wait_clk(4 * HALF);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer_bits(b, 8, r);
    got.push_back(r);
  endtask

  // behavioural reference for the bytes a read returns
  task automatic model(input logic [7:0] cmd);
    exp_q.delete();
    case (cmd)
      8'h04: begin exp_q.push_back({6'b0, cur[9:8]});  exp_q.push_back(cur[7:0]);  end
      8'h05: begin exp_q.push_back({6'b0, vin[9:8]});  exp_q.push_back(vin[7:0]);  end
      8'h06: begin exp_q.push_back({7'b0, duty[8]});   exp_q.push_back(duty[7:0]); end
      8'h07: exp_q.push_back({1'b0, oc, ov, ot, aux});
      default: ;
    endcase
  endtask

  task automatic compare(input string req);
    check({"R10 cmd-byte ", req}, int'(got[0]), 0);
    for (int i = 1; i < got.size(); i++) begin
      int e;
      e = (i - 1 < exp_q.size()) ? int'(exp_q[i-1]) : 0;
      check(req, int'(got[i]), e);
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input int nfill, input string req);
    got.delete();
    model(cmd);
    sel_low();
    send(cmd);
    for (int i = 0; i < nfill; i++) send(8'h00);
    sel_high();
    compare(req);
  endtask

  initial begin
    int s0, o0;
    logic [7:0] dummy;
    wait_clk(10);
    check("R1 miso in reset", int'(miso), 0);
    check("R1 shutdown in reset", int'(shut), 0);
    check("R1 turn_on in reset", int'(on), 0);
    rst_ni = 1'b1;
    wait_clk(10);
    check("R1 miso idle", int'(miso), 0);

    s0 = n_shut; o0 = n_on;
    frame(8'h01, 2, "R11 nop");
    check("R11 nop no pulse", n_shut + n_on, s0 + o0);

    frame(8'h02, 0, "R3 shut");
    check("R3 shutdown count", n_shut, s0 + 1);
    frame(8'h03, 0, "R4 on");
    check("R4 turn_on count", n_on, o0 + 1);

    cur = 10'h3A5; frame(8'h04, 3, "R2 R5 current");
    vin = 10'h15A; frame(8'h05, 2, "R6 vin");
    duty = 9'h1F0; frame(8'h06, 3, "R7 duty");
    oc = 4'b1010; ov = 1'b1; ot = 1'b0; aux = 1'b1;
    frame(8'h07, 2, "R8 status");
    check("R8 status packing", int'(got[1]), 8'h55);
    cur = 10'h2C3; frame(8'h04, 1, "R5 short read");

    // R9: value changes after decode
    cur = 10'h155;
    got.delete(); model(8'h04);
    sel_low(); send(8'h04);
    cur = 10'h2AA;
    send(8'h00); send(8'h00);
    sel_high();
    compare("R9 capture");

    s0 = n_shut; o0 = n_on;
    frame(8'h00, 2, "R11 reserved");
    frame(8'h9C, 2, "R11 unknown");
    check("R11 no pulse", n_shut + n_on, s0 + o0);

    // R12: abort inside a shutdown byte
    s0 = n_shut; o0 = n_on;
    sel_low(); xfer_bits(8'h02, 7, dummy); sel_high();
    wait_clk(20);
    check("R12 aborted shutdown", n_shut, s0);
    frame(8'h03, 0, "R12 next frame");
    check("R12 fresh command", n_on, o0 + 1);
    // abort inside a data byte, then a full read
    vin = 10'h2E7;
    sel_low(); send(8'h05); xfer_bits(8'h00, 3, dummy); sel_high();
    frame(8'h05, 2, "R12 read after abort");

    // R13: control codes as later bytes
    s0 = n_shut; o0 = n_on;
    got.delete(); exp_q.delete();
    sel_low(); send(8'h01); send(8'h02); send(8'h03); sel_high();
    compare("R13 later bytes");
    check("R13 no pulse", n_shut + n_on, s0 + o0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule